// File: doc/BRIEF.md
# Bus Width Adapter with Byte Order Select

This block sits between the write side and the read side of a queue and changes the word width on the way through. It can split each 36-bit word into two 18-bit pieces or four 9-bit pieces, assemble 18-bit or 9-bit pieces into 36-bit words, or pass 36-bit words through unchanged. Both sides use a valid/ready handshake. A transfer happens on a rising clock edge where valid and ready are both high.

Four configuration straps are captured on every clock edge while the synchronous active-low reset is low. They are ignored once reset is released. One strap enables width matching. Two width straps then choose one of four pairings. The fourth strap chooses big-endian order (low) or little-endian order (high). The same order controls the sequence in which pieces leave a wide word and the slot that each arriving piece fills. Narrow pieces always travel on the low bits of the data bus.

Top module: `bus_width_adapter`

## Requirements
- R1: After reset is released, `outValid` is low and `inReady` is high.
- R2: The straps are captured only while `rstN` is low. Changing them after reset does not change the width pairing or the byte order.
- R3: When `strapMatch` is low, each accepted 36-bit word appears unchanged on `outData` with `outValid` high. This happens one cycle after the accepting edge, in any setting of the other straps.
- R4: When `strapMatch`=1, `strapInNarrow`=0 and `strapOutNarrow`=0 (36 in, 18 out), each word leaves as two pieces on `outData[17:0]`. In big-endian order `inData[35:18]` comes first, then `[17:0]`.
- R5: When `strapMatch`=1, `strapInNarrow`=0 and `strapOutNarrow`=1 (36 in, 9 out), each word leaves as four pieces on `outData[8:0]`. In big-endian order they are bits [35:27], [26:18], [17:9] and [8:0], in that sequence.
- R6: When `strapMatch`=1, `strapInNarrow`=1 and `strapOutNarrow`=0 (18 in, 36 out), two pieces taken from `inData[17:0]` form one word. In big-endian order the first piece lands in bits [35:18].
- R7: When `strapMatch`=1, `strapInNarrow`=1 and `strapOutNarrow`=1 (9 in, 36 out), four pieces taken from `inData[8:0]` form one word. In big-endian order the first piece lands in bits [35:27], and later pieces fill lower slots.
- R8: With `strapLittle` high, the order of R4 to R7 is reversed. The least significant piece leaves first when splitting, and the first piece received fills the least significant slot when packing.
- R9: A packed word is offered only after all of its pieces have been accepted. A reset discards any partly packed or partly split word.
- R10: While `outValid` is high and `outReady` is low, `outValid` and `outData` hold their values. No piece is lost or repeated, and a splitting adapter accepts no new word until the last piece of the current word is taken.
- R11: In the packing modes, `inData` bits above the piece width have no effect on the assembled word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rstN | input | 1 | Synchronous active-low reset; straps are captured while it is low |
| strapMatch | input | 1 | 0: 36 to 36 pass-through; 1: width matching enabled |
| strapInNarrow | input | 1 | With matching on: 0 means a 36-bit input, 1 means a narrow input |
| strapOutNarrow | input | 1 | With matching on: 0 means the narrow side is 18 bits, 1 means 9 bits |
| strapLittle | input | 1 | 0: big-endian piece order; 1: little-endian |
| inData | input | 36 | Input word or piece; narrow pieces use the low bits |
| inValid | input | 1 | Input word or piece is present |
| inReady | output | 1 | Adapter can take the input this cycle |
| outData | output | 36 | Output word or piece; narrow pieces use the low bits, upper bits zero |
| outValid | output | 1 | Output word or piece is present |
| outReady | input | 1 | Downstream takes the output this cycle |

## Verification
The assertions check the handshake rules on every cycle:
- the output holds steady under backpressure;
- a splitting adapter refuses new words while pieces are still pending;
- pass-through never stalls an empty stage;
- a packed word appears only after an input handshake;
- the latched mode never changes outside reset.

Only the bench scenarios can show that piece order and slot placement match the byte order for each pairing. The same holds for showing that a strap change after reset has no effect and that a reset drops a half-built word.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

  // Narrowest split of a wide word; the half split uses LANES/2 pieces.
  localparam int unsigned BWA_LANES = 4;
  localparam int unsigned BWA_CNT_W = $clog2(BWA_LANES);

  typedef enum logic [2:0] {
    MODE_PASS          = 3'd0,
    MODE_SPLIT_HALF    = 3'd1,
    MODE_SPLIT_QUARTER = 3'd2,
    MODE_PACK_HALF     = 3'd3,
    MODE_PACK_QUARTER  = 3'd4
  } bwa_mode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic                 loadWide;  // capture a full input word
    logic                 loadSlot;  // write one narrow piece into a slot
    logic                 quarter;   // piece size is a quarter (else half)
    logic                 selPiece;  // output a single slot instead of the word
    logic [BWA_CNT_W-1:0] slot;      // physical slot to write or read
  } bwa_strobe_t;

  function automatic bwa_mode_e decodeStraps(input logic matchOn,
                                             input logic inNarrow,
                                             input logic outNarrow);
    if (!matchOn)  return MODE_PASS;
    if (!inNarrow) return outNarrow ? MODE_SPLIT_QUARTER : MODE_SPLIT_HALF;
    return outNarrow ? MODE_PACK_QUARTER : MODE_PACK_HALF;
  endfunction

endpackage

// File: rtl/bwa_ctrl.sv
module bwa_ctrl
  import bwa_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        strapMatch,
  input  logic        strapInNarrow,
  input  logic        strapOutNarrow,
  input  logic        strapLittle,
  input  logic        inValid,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output bwa_strobe_t strobe,
  output bwa_mode_e   modeQ
);

  localparam logic [BWA_CNT_W-1:0] LAST_QUARTER = BWA_CNT_W'(BWA_LANES - 1);
  localparam logic [BWA_CNT_W-1:0] LAST_HALF    = BWA_CNT_W'(BWA_LANES / 2 - 1);

  logic                 littleQ;
  logic                 validQ, validD;
  logic [BWA_CNT_W-1:0] cntQ, cntD;
  logic [BWA_CNT_W-1:0] lastIdx, physSlot;
  logic                 isSplit, isPack, quarter;
  logic                 fire, lastPiece, accept;

  always_comb begin
    isSplit   = (modeQ == MODE_SPLIT_HALF) || (modeQ == MODE_SPLIT_QUARTER);
    isPack    = (modeQ == MODE_PACK_HALF)  || (modeQ == MODE_PACK_QUARTER);
    quarter   = (modeQ == MODE_SPLIT_QUARTER) || (modeQ == MODE_PACK_QUARTER);
    lastIdx   = quarter ? LAST_QUARTER : LAST_HALF;
    lastPiece = (cntQ == lastIdx);
    physSlot  = littleQ ? cntQ : (lastIdx - cntQ);
    fire      = validQ && outReady;
    if (isSplit) inReady = !validQ || (outReady && lastPiece);
    else         inReady = !validQ || outReady;
    accept    = inValid && inReady;
  end

  always_comb begin
    validD = validQ;
    cntD   = cntQ;
    unique case (1'b1)
      isSplit: begin
        if (fire) begin
          if (lastPiece) begin
            cntD   = '0;
            validD = accept;
          end else begin
            cntD   = cntQ + BWA_CNT_W'(1);
          end
        end else if (accept) begin
          cntD   = '0;
          validD = 1'b1;
        end
      end
      isPack: begin
        validD = validQ && !outReady;
        if (accept) begin
          if (lastPiece) begin
            cntD   = '0;
            validD = 1'b1;
          end else begin
            cntD   = cntQ + BWA_CNT_W'(1);
          end
        end
      end
      default: begin
        cntD   = '0;
        validD = accept || (validQ && !outReady);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= decodeStraps(strapMatch, strapInNarrow, strapOutNarrow);
      littleQ <= strapLittle;
      validQ  <= 1'b0;
      cntQ    <= '0;
    end else begin
      validQ  <= validD;
      cntQ    <= cntD;
    end
  end

  always_comb begin
    strobe.loadWide = accept && !isPack;
    strobe.loadSlot = accept && isPack;
    strobe.quarter  = quarter;
    strobe.selPiece = isSplit;
    strobe.slot     = physSlot;
  end

  assign outValid = validQ;

endmodule

// File: rtl/bwa_datapath.sv
module bwa_datapath
  import bwa_pkg::*;
#(
  parameter int unsigned WIDE_W = 36
) (
  input  logic              clk,
  input  logic              rstN,
  input  bwa_strobe_t       strobe,
  input  logic [WIDE_W-1:0] inData,
  output logic [WIDE_W-1:0] outData
);

  localparam int unsigned HALVES = BWA_LANES / 2;
  localparam int unsigned Q_W    = WIDE_W / BWA_LANES;
  localparam int unsigned H_W    = WIDE_W / HALVES;
  localparam int unsigned HSEL_W = (HALVES > 1) ? $clog2(HALVES) : 1;

  logic [WIDE_W-1:0] wideQ;
  logic [Q_W-1:0]    quarterPiece [BWA_LANES];
  logic [H_W-1:0]    halfPiece    [HALVES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wideQ <= '0;
    end else if (strobe.loadWide) begin
      wideQ <= inData;
    end else if (strobe.loadSlot) begin
      if (strobe.quarter)
        wideQ[32'(strobe.slot) * Q_W +: Q_W] <= inData[Q_W-1:0];
      else
        wideQ[32'(strobe.slot[HSEL_W-1:0]) * H_W +: H_W] <= inData[H_W-1:0];
    end
  end

  for (genvar gq = 0; gq < BWA_LANES; gq++) begin : g_quarter
    assign quarterPiece[gq] = wideQ[gq*Q_W +: Q_W];
  end

  for (genvar gh = 0; gh < HALVES; gh++) begin : g_half
    assign halfPiece[gh] = wideQ[gh*H_W +: H_W];
  end

  always_comb begin
    if (!strobe.selPiece)    outData = wideQ;
    else if (strobe.quarter) outData = WIDE_W'(quarterPiece[strobe.slot]);
    else                     outData = WIDE_W'(halfPiece[strobe.slot[HSEL_W-1:0]]);
  end

endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
  import bwa_pkg::*;
#(
  parameter int unsigned WIDE_W = 36
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapMatch,
  input  logic              strapInNarrow,
  input  logic              strapOutNarrow,
  input  logic              strapLittle,
  input  logic [WIDE_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic [WIDE_W-1:0] outData,
  output logic              outValid,
  input  logic              outReady
);

  bwa_strobe_t strobe;
  bwa_mode_e   modeQ;

  bwa_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .strapMatch     (strapMatch),
    .strapInNarrow  (strapInNarrow),
    .strapOutNarrow (strapOutNarrow),
    .strapLittle    (strapLittle),
    .inValid        (inValid),
    .outReady       (outReady),
    .inReady        (inReady),
    .outValid       (outValid),
    .strobe         (strobe),
    .modeQ          (modeQ)
  );

  bwa_datapath #(.WIDE_W(WIDE_W)) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inData  (inData),
    .outData (outData)
  );

endmodule

// File: rtl/bwa_checker.sv
module bwa_checker
  import bwa_pkg::*;
#(
  parameter int unsigned WIDE_W = 36
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic [WIDE_W-1:0] outData,
  input logic              outValid,
  input logic              outReady,
  input bwa_mode_e         modeQ
);

  logic splitMode, packMode;
  assign splitMode = (modeQ == MODE_SPLIT_HALF) || (modeQ == MODE_SPLIT_QUARTER);
  assign packMode  = (modeQ == MODE_PACK_HALF)  || (modeQ == MODE_PACK_QUARTER);

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData)); // R10

  AST_SPLIT_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    splitMode && outValid && !outReady |-> !inReady); // R10

  AST_PASS_READY: assert property (@(posedge clk) disable iff (!rstN)
    modeQ == MODE_PASS && !outValid |-> inReady); // R3

  AST_PACK_AFTER_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    packMode && $rose(outValid) |-> $past(inValid && inReady)); // R9

  AST_MODE_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $stable(modeQ)); // R2

endmodule

bind bus_width_adapter bwa_checker #(.WIDE_W(WIDE_W)) u_bwaChk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .outData  (outData),
  .outValid (outValid),
  .outReady (outReady),
  .modeQ    (modeQ)
);

// File: tb/bus_width_adapter_bench.sv
`timescale 1ns/1ps
module bus_width_adapter_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        strapMatch = 1'b0, strapInNarrow = 1'b0;
  logic        strapOutNarrow = 1'b0, strapLittle = 1'b0;
  logic [35:0] inData = '0;
  logic        inValid = 1'b0, outReady = 1'b0;
  logic        inReady, outValid;
  logic [35:0] outData;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bus_width_adapter u_bus_width_adapter (
    .clk(clk), .rstN(rstN),
    .strapMatch(strapMatch), .strapInNarrow(strapInNarrow),
    .strapOutNarrow(strapOutNarrow), .strapLittle(strapLittle),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .outData(outData), .outValid(outValid), .outReady(outReady)
  );

  // {match, inNarrow, outNarrow, little, word}
  localparam logic [39:0] VEC [10] = '{
    {4'b0000, 36'h123456789}, {4'b0001, 36'hFEDCBA987},
    {4'b1000, 36'h2468ACE13}, {4'b1001, 36'h13579BDF0},
    {4'b1010, 36'h0F1E2D3C4}, {4'b1011, 36'hA5A5C3C3E},
    {4'b1100, 36'h1A2B3C4D5}, {4'b1101, 36'h9876FEDC1},
    {4'b1110, 36'h3C3C5A5A7}, {4'b1111, 36'hB4E1D2C3F}
  };

  task automatic check(input bit ok, input string req,
                       input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int lanesOf(input logic [3:0] cfg);
    return cfg[1] ? 4 : 2;
  endfunction

  function automatic logic [35:0] pieceOf(input logic [35:0] w, input int n,
                                          input int k, input bit little);
    int p = 36 / n;
    int phys = little ? k : n - 1 - k;
    return (w >> (phys * p)) & ((36'h1 << p) - 36'h1);
  endfunction

  task automatic doReset(input logic [3:0] cfg);
    @(negedge clk);
    rstN = 1'b0; inValid = 1'b0; outReady = 1'b0;
    {strapMatch, strapInNarrow, strapOutNarrow, strapLittle} = cfg;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #0.5;
  endtask

  task automatic pushIn(input logic [35:0] d);
    inValid = 1'b1;
    inData  = d;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic pullOut(output logic [35:0] d);
    outReady = 1'b1;
    while (!outValid) @(negedge clk);
    d = outData;
    @(negedge clk);
    outReady = 1'b0;
  endtask

  task automatic runPack(input logic [35:0] w, input int n, input bit little, input int count);
    for (int k = 0; k < count; k++) begin
      logic [35:0] mask = (36'h1 << (36 / n)) - 36'h1;
      pushIn((~w & ~mask) | pieceOf(w, n, k, little)); // R11 garbage upper bits
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired actual=%h expected=%h", 36'h0, 36'h1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [35:0] got;
    logic [35:0] w;
    logic [3:0]  cfg;

    for (int v = 0; v < 10; v++) begin
      cfg = VEC[v][39:36];
      w   = VEC[v][35:0];
      doReset(cfg);
      check(!outValid && inReady, "R1", {34'h0, outValid, inReady}, 36'h1);
      if (!cfg[3]) begin
        pushIn(w);
        pullOut(got);
        check(got == w, "R3", got, w);
      end else if (!cfg[2]) begin
        pushIn(w);
        for (int k = 0; k < lanesOf(cfg); k++) begin
          pullOut(got);
          check(got == pieceOf(w, lanesOf(cfg), k, cfg[0]),
                cfg[0] ? "R8" : (cfg[1] ? "R5" : "R4"),
                got, pieceOf(w, lanesOf(cfg), k, cfg[0]));
        end
        check(!outValid, "R10", {35'h0, outValid}, 36'h0);
      end else begin
        runPack(w, lanesOf(cfg), cfg[0], lanesOf(cfg));
        pullOut(got);
        check(got == w, cfg[0] ? "R8" : (cfg[1] ? "R7" : "R6"), got, w);
        check(got == w, "R11", got, w);
      end
    end

    // R3 latency: data visible one cycle after the accepting edge
    doReset(4'b0000);
    inValid = 1'b1; inData = 36'h5A5A5A5A5;
    @(negedge clk);
    inValid = 1'b0;
    check(outValid && outData == 36'h5A5A5A5A5, "R3", outData, 36'h5A5A5A5A5);
    check(!inReady, "R10", {35'h0, inReady}, 36'h0);
    pullOut(got);

    // R2: strap change after reset is ignored (stays 36 to 18, big-endian)
    doReset(4'b1000);
    strapMatch = 1'b0; strapInNarrow = 1'b1; strapOutNarrow = 1'b1; strapLittle = 1'b1;
    w = 36'hABCDE1234;
    pushIn(w);
    for (int k = 0; k < 2; k++) begin
      pullOut(got);
      check(got == pieceOf(w, 2, k, 1'b0), "R2", got, pieceOf(w, 2, k, 1'b0));
    end

    // R9: partial pack not offered, then dropped by reset
    doReset(4'b1110);
    runPack(36'h111111111, 4, 1'b0, 3);
    repeat (2) @(negedge clk);
    check(!outValid, "R9", {35'h0, outValid}, 36'h0);
    doReset(4'b1110);
    w = 36'h876543210;
    runPack(w, 4, 1'b0, 4);
    pullOut(got);
    check(got == w, "R9", got, w);

    // R10: backpressure during a 36 to 9 split, second word queued
    doReset(4'b1010);
    w = 36'hC0FFEE123;
    pushIn(w);
    repeat (3) @(negedge clk);
    check(outValid && outData == pieceOf(w, 4, 0, 1'b0), "R10", outData, pieceOf(w, 4, 0, 1'b0));
    check(!inReady, "R10", {35'h0, inReady}, 36'h0);
    inValid = 1'b1; inData = 36'h0DEADBEEF;
    for (int k = 0; k < 4; k++) begin
      pullOut(got);
      check(got == pieceOf(w, 4, k, 1'b0), "R5", got, pieceOf(w, 4, k, 1'b0));
    end
    inValid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      pullOut(got);
      check(got == pieceOf(36'h0DEADBEEF, 4, k, 1'b0), "R10", got,
            pieceOf(36'h0DEADBEEF, 4, k, 1'b0));
    end
    check(!outValid, "R10", {35'h0, outValid}, 36'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule